// File: doc/BRIEF.md
# Delay-Line Sampling Phase Loader

This block is a small control sequencer that installs a new sampling phase, a value from 0 to 15, into the configuration word of a programmable delay line. It is started by a one-cycle pulse that carries the phase. It reads a live copy of the configuration word and issues a fixed series of read-modify-write strobes, each of which changes a few control bits. Between the writes it waits on the clock-output enable bit, which the delay line itself drives.

The series runs as follows. The first write stops recovery from tracking and hands control to the external phase select. The block then waits for the clock output to drop. Next it writes the Gray-coded phase into the select field and turns the clock output back on. After the clock output is seen high, the last write returns recovery to internal tracking. Each wait polls once on entry and then once on every 1 µs tick, up to a parameterised limit. If a wait runs out, the block ends at once with an error, and the error is reported together with the done pulse.

Top module: `dll_phase_seq`

## Requirements
- R1: The first write takes the current word and clears bit 17 (recovery enable) and bit 18 (clock-output enable). It sets bit 19 (external select) and bit 16 (delay-line enable).
- R2: After the first write the block waits until bit 18 of the read word is 0. It polls on the first cycle of the wait and again on each cycle where the tick input is high. After POLLS (default 50) failed polls the wait ends in a timeout.
- R3: The second write places the Gray code of the captured phase (p XOR p>>1, so 0..15 map to 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8) into bits 23:20 and leaves every other bit unchanged.
- R4: The write in the cycle right after the second write sets bit 18. The block then waits for bit 18 to read 1, under the same polling rule and limit as R2.
- R5: The final write sets bit 17 and clears bit 19. One cycle later done_o pulses for exactly one cycle.
- R6: Every write copies all bits it does not name (15:0, 31:24 and the untouched control bits) from the read word of that same cycle.
- R7: On a timeout, done_o and err_o go high together for one cycle and no further write strobe follows. A timeout in the first wait gives 1 write in total; a timeout in the second wait gives 3.
- R8: A start pulse that arrives while a sequence is running, including the done cycle, has no effect: the phase written stays the captured one and no extra sequence follows.
- R9: A sequence that completes without a timeout gives exactly 4 writes and err_o stays low throughout.
- R10: While reset is high, and right after it, wr_en_o, done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to load a phase |
| phase_i | input | 4 | Phase to load, sampled with start_i |
| cfg_rd_i | input | 32 | Live value of the configuration word |
| tick_i | input | 1 | One-cycle pulse every 1 µs |
| wr_en_o | output | 1 | Write strobe for the configuration word |
| wr_data_o | output | 32 | Value to write when wr_en_o is high |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | High with done_o when a wait timed out |

## Verification
The assertions check the following on every cycle:
- the bit pattern of the first and last writes;
- that unnamed fields are copied into every write;
- that the poll counter never exceeds its limit;
- that done is a single pulse and an error only appears with done.

Only the bench scenarios can show:
- the Gray mapping for chosen phases;
- the exact cycle where each wait passes or expires against a delayed status bit;
- the write counts of the two timeout paths;
- that start pulses during a run are ignored.

The bench compares each clock with a behavioural model that follows the requirements.

// File: rtl/dll_phase_pkg.sv
package dll_phase_pkg;
    localparam int CFG_W      = 32;
    localparam int PH_W       = 4;
    localparam int DLL_EN_BIT = 16;
    localparam int CDR_EN_BIT = 17;
    localparam int CKOUT_BIT  = 18;
    localparam int EXTSEL_BIT = 19;
    localparam int SEL_LSB    = 20;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HANDOFF, ST_WAIT_LO, ST_FIELD,
        ST_RAISE, ST_WAIT_HI, ST_FINAL, ST_END
    } seq_state_t;

    typedef enum logic [1:0] {
        WK_HANDOFF, WK_FIELD, WK_RAISE, WK_FINAL
    } wr_kind_t;

    function automatic logic [PH_W-1:0] to_gray(input logic [PH_W-1:0] b);
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/dps_cfg_word.sv
module dps_cfg_word
    import dll_phase_pkg::*;
(
    input  wr_kind_t               kind_i,
    input  logic [CFG_W-1:0]       cur_i,
    input  logic [PH_W-1:0]        code_i,
    output logic [CFG_W-1:0]       word_o
);
    always_comb begin
        word_o = cur_i;
        unique case (kind_i)
            WK_HANDOFF: begin
                word_o[CDR_EN_BIT] = 1'b0;
                word_o[CKOUT_BIT]  = 1'b0;
                word_o[EXTSEL_BIT] = 1'b1;
                word_o[DLL_EN_BIT] = 1'b1;
            end
            WK_FIELD:  word_o[SEL_LSB +: PH_W] = code_i;
            WK_RAISE:  word_o[CKOUT_BIT] = 1'b1;
            WK_FINAL: begin
                word_o[CDR_EN_BIT] = 1'b1;
                word_o[EXTSEL_BIT] = 1'b0;
            end
            default: word_o = cur_i;
        endcase
    end
endmodule

// File: rtl/dps_poll_timer.sv
module dps_poll_timer #(
    parameter int POLLS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic active_i,
    input  logic tick_i,
    input  logic miss_i,
    output logic poll_o,
    output logic expire_o
);
    localparam int CNT_W = $clog2(POLLS + 1);

    logic             first_q;
    logic [CNT_W-1:0] cnt_q;

    assign poll_o   = active_i & (first_q | tick_i);
    assign expire_o = poll_o & miss_i & (cnt_q == CNT_W'(POLLS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
            cnt_q   <= '0;
        end else if (arm_i) begin
            first_q <= 1'b1;
            cnt_q   <= '0;
        end else begin
            if (active_i)
                first_q <= 1'b0;
            if (poll_o && miss_i && !expire_o)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the failed-poll count stays below the limit
    a_r2_poll_cap: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(POLLS));
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
    import dll_phase_pkg::*;
#(
    parameter int POLLS = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [3:0]       phase_i,
    input  logic [31:0]      cfg_rd_i,
    input  logic             tick_i,
    output logic             wr_en_o,
    output logic [31:0]      wr_data_o,
    output logic             done_o,
    output logic             err_o
);
    seq_state_t      state_q, state_d;
    logic [PH_W-1:0] phase_q;
    logic            err_q;
    wr_kind_t        kind;
    logic            arm, active, miss, poll, expire;

    always_comb begin
        state_d = state_q;
        kind    = WK_HANDOFF;
        wr_en_o = 1'b0;
        arm     = 1'b0;
        active  = 1'b0;
        miss    = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_HANDOFF;
            ST_HANDOFF: begin
                wr_en_o = 1'b1; kind = WK_HANDOFF; arm = 1'b1;
                state_d = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                active = 1'b1;
                miss   = cfg_rd_i[CKOUT_BIT];
                if (poll && !miss) state_d = ST_FIELD;
                else if (expire)   state_d = ST_END;
            end
            ST_FIELD: begin
                wr_en_o = 1'b1; kind = WK_FIELD;
                state_d = ST_RAISE;
            end
            ST_RAISE: begin
                wr_en_o = 1'b1; kind = WK_RAISE; arm = 1'b1;
                state_d = ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                active = 1'b1;
                miss   = !cfg_rd_i[CKOUT_BIT];
                if (poll && !miss) state_d = ST_FINAL;
                else if (expire)   state_d = ST_END;
            end
            ST_FINAL: begin
                wr_en_o = 1'b1; kind = WK_FINAL;
                state_d = ST_END;
            end
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i)
                phase_q <= phase_i;
            if (active && expire)
                err_q <= 1'b1;
            else if (state_q == ST_END)
                err_q <= 1'b0;
        end
    end

    assign done_o = (state_q == ST_END);
    assign err_o  = done_o & err_q;

    dps_poll_timer #(.POLLS(POLLS)) u_timer (
        .clk(clk), .rst(rst), .arm_i(arm), .active_i(active),
        .tick_i(tick_i), .miss_i(miss), .poll_o(poll), .expire_o(expire)
    );

    dps_cfg_word u_word (
        .kind_i(kind), .cur_i(cfg_rd_i), .code_i(to_gray(phase_q)),
        .word_o(wr_data_o)
    );

    // R1: handoff write pattern
    a_r1_handoff_bits: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HANDOFF) |-> (wr_en_o && wr_data_o[19] && wr_data_o[16]
                                     && !wr_data_o[17] && !wr_data_o[18]));
    // R5: last write pattern
    a_r5_final_bits: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FINAL) |-> (wr_en_o && wr_data_o[17] && !wr_data_o[19]));
    // R6: unnamed fields copied from the read word
    a_r6_keep_fields: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_data_o[15:0] == cfg_rd_i[15:0]
                     && wr_data_o[31:24] == cfg_rd_i[31:24]));
    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R7: error only with done, and no write alongside or right after
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (done_o && !wr_en_o));
    a_r7_quiet_after: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !wr_en_o);
endmodule

// File: tb/tb_dll_phase_seq.sv
module tb_dll_phase_seq;
    localparam int POLLS = 50;
    localparam int TICK_DIV = 5;
    localparam logic [3:0] GRAY_T [16] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7,
        4'h5, 4'h4, 4'hC, 4'hD, 4'hF, 4'hE, 4'hA, 4'hB, 4'h9, 4'h8};

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, tick = 1'b0;
    logic [3:0] phase = '0;
    logic [31:0] rd;
    logic wr_en, done, err;
    logic [31:0] wr_data;

    int checks = 0, fails = 0, cyc = 0, nwr = 0;

    always #10 clk = ~clk;

    dll_phase_seq #(.POLLS(POLLS)) dut (
        .clk(clk), .rst(rst), .start_i(start), .phase_i(phase),
        .cfg_rd_i(rd), .tick_i(tick), .wr_en_o(wr_en), .wr_data_o(wr_data),
        .done_o(done), .err_o(err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // tick generator
    int tdiv = 0;
    always @(posedge clk) begin
        tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == TICK_DIV - 1);
    end

    // configuration register model with delayed clock-output status
    logic [31:0] rf = '0;
    logic ck_s = 1'b0;
    int dly = 0, dcnt = 0, stuck = 0;
    logic [31:0] pre_val = '0;
    bit pre_go = 0;
    always_comb begin
        rd = rf;
        rd[18] = (stuck == 1) ? 1'b1 : (stuck == 2) ? 1'b0 : ck_s;
    end
    always @(posedge clk) begin
        logic [31:0] nrf;
        nrf = wr_en ? wr_data : rf;
        if (pre_go) nrf = pre_val;
        rf <= nrf;
        if (pre_go) begin
            ck_s <= pre_val[18]; dcnt <= 0;
        end else if (ck_s != nrf[18]) begin
            if (dcnt + 1 > dly) begin ck_s <= nrf[18]; dcnt <= 0; end
            else dcnt <= dcnt + 1;
        end else dcnt <= 0;
    end

    // behavioural reference model
    int ms = 0, mpolls = 0;
    bit mfirst = 0, merr = 0;
    logic [3:0] mph = '0;
    logic exp_wr, exp_done, exp_err;
    logic [31:0] exp_data;
    always_comb begin
        exp_data = rd;
        exp_wr = (ms == 1 || ms == 3 || ms == 4 || ms == 6);
        case (ms)
            1: begin exp_data[17] = 0; exp_data[18] = 0; exp_data[19] = 1; exp_data[16] = 1; end
            3: exp_data[23:20] = GRAY_T[mph];
            4: exp_data[18] = 1;
            6: begin exp_data[17] = 1; exp_data[19] = 0; end
            default: ;
        endcase
        exp_done = (ms == 7);
        exp_err  = (ms == 7) && merr;
    end
    always @(posedge clk) begin
        if (rst) begin
            ms <= 0; merr <= 0; mfirst <= 0; mpolls <= 0;
        end else case (ms)
            0: if (start) begin ms <= 1; mph <= phase; end
            1, 4: begin ms <= ms + 1; mfirst <= 1; mpolls <= 0; end
            2, 5: begin
                mfirst <= 0;
                if (mfirst || tick) begin
                    if (rd[18] == (ms == 5)) ms <= ms + 1;
                    else if (mpolls == POLLS - 1) begin ms <= 7; merr <= 1; end
                    else mpolls <= mpolls + 1;
                end
            end
            3: ms <= 4;
            6: ms <= 7;
            7: begin ms <= 0; merr <= 0; end
            default: ms <= 0;
        endcase
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (wr_en) nwr++;
        if (!rst) begin
            check(wr_en == exp_wr, "R2/R4 strobe timing", {31'b0, wr_en}, {31'b0, exp_wr});
            if (exp_wr)
                check(wr_data == exp_data, "R1/R3/R5/R6 write data", wr_data, exp_data);
            check(done == exp_done, "R5 done timing", {31'b0, done}, {31'b0, exp_done});
            check(err == exp_err, "R7 error flag", {31'b0, err}, {31'b0, exp_err});
        end
    end

    task automatic wait_done(output bit e);
        int n = 0;
        e = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        e = err;
        check(done == 1'b1, "R5 done reached", {31'b0, done}, 32'h1);
    endtask

    task automatic run(input logic [3:0] ph, input int d, input int stk,
                       input logic [31:0] init, input bit poke,
                       output bit e, output int writes);
        int w0;
        @(negedge clk);
        pre_val = init; pre_go = 1; dly = d; stuck = stk;
        @(negedge clk);
        pre_go = 0;
        w0 = nwr;
        start = 1; phase = ph;
        @(negedge clk);
        start = 0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1; phase = ~ph;
            @(negedge clk);
            start = 0;
        end
        wait_done(e);
        if (poke) begin
            start = 1; phase = ~ph;   // start during the done cycle
        end
        @(negedge clk);
        start = 0;
        repeat (20) @(negedge clk);
        writes = nwr - w0;
    endtask

    task automatic check_ok(input logic [3:0] ph, input logic [31:0] init,
                            input bit e, input int writes);
        check(rd[23:20] == GRAY_T[ph], "R3 gray field", {28'b0, rd[23:20]}, {28'b0, GRAY_T[ph]});
        check(rd[16] && rd[17] && rd[18] && !rd[19], "R1/R5 control bits",
              {28'b0, rd[19:16]}, 32'h7);
        check(rd[15:0] == init[15:0] && rd[31:24] == init[31:24], "R6 preserved",
              rd, init);
        check(writes == 4, "R9 write count", writes, 4);
        check(e == 1'b0, "R9 no error", {31'b0, e}, 32'h0);
    endtask

    initial begin
        bit e;
        int w;
        repeat (3) @(negedge clk);
        check(!wr_en && !done && !err, "R10 reset outputs", {29'b0, wr_en, done, err}, 0);
        rst = 0;
        @(negedge clk);
        check(!wr_en && !done && !err, "R10 idle after reset", {29'b0, wr_en, done, err}, 0);

        run(4'd0, 0, 0, 32'hA5C3_0F0F, 0, e, w);  check_ok(4'd0, 32'hA5C3_0F0F, e, w);
        run(4'd5, 7, 0, 32'h5A34_1234, 0, e, w);  check_ok(4'd5, 32'h5A34_1234, e, w);
        run(4'd10, 30, 0, 32'hFF0F_FFFF, 0, e, w); check_ok(4'd10, 32'hFF0F_FFFF, e, w);
        run(4'd15, 2, 0, 32'h0000_0000, 0, e, w); check_ok(4'd15, 32'h0000_0000, e, w);
        run(4'd8, 3, 0, 32'h1234_5678, 0, e, w);  check_ok(4'd8, 32'h1234_5678, e, w);
        // R8: start pulses mid-run and in the done cycle are ignored
        run(4'd3, 12, 0, 32'hC0DE_0001, 1, e, w); check_ok(4'd3, 32'hC0DE_0001, e, w);
        // R2: close to the poll limit, model decides the outcome
        run(4'd12, 235, 0, 32'h0000_0000, 0, e, w);
        // R7/R2: clock output never drops -> timeout in first wait
        run(4'd6, 0, 1, 32'h0004_0000, 0, e, w);
        check(e == 1'b1, "R7 timeout low error", {31'b0, e}, 1);
        check(w == 1, "R7 timeout low writes", w, 1);
        // R7/R4: clock output never rises -> timeout in second wait
        run(4'd9, 0, 2, 32'h0000_0000, 0, e, w);
        check(e == 1'b1, "R7 timeout high error", {31'b0, e}, 1);
        check(w == 3, "R7 timeout high writes", w, 3);
        // recovery after an error
        run(4'd1, 1, 0, 32'h7777_0000, 0, e, w);  check_ok(4'd1, 32'h7777_0000, e, w);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule